// File: doc/BRIEF.md
# Load Wait-Bit Ordering Predictor

This block advises the issue stage whether a load may run ahead of older stores whose addresses are still unknown. It holds a table of one-bit wait flags indexed by a slice of the load's program counter. When a load's flag is clear, the load may issue speculatively past unresolved stores. When the flag is set, the load is held back until every older store has resolved its address.

When the memory pipeline finds that a load returned stale data, it reports that load's PC. The cause is an older store to the same address that executed after the load. The report sets the flag for that PC, so later instances of the load issue conservatively. A free-running interval counter clears the whole table at a fixed period, so loads that have stopped conflicting regain speculative issue. Violation detection and instruction replay are handled elsewhere.

Top module: `ldwait_predictor`

## Requirements
- R1: After a synchronous reset, every lookup returns a wait flag of 0.
- R2: A violation report with `violValid`=1 sets the entry selected by `violPc[11:2]`. A lookup of any PC with the same bits [11:2] returns 1 from the cycle after the report.
- R3: The lookup is combinational from the current table. A lookup in the same cycle as a report to the same entry returns the flag as it was before that report.
- R4: Only PC bits [11:2] select the entry. PCs that differ only in bits [1:0] or in bits above 11 read and write the same flag.
- R5: A report changes only the selected entry. Entries with a different index keep their value.
- R6: The table has 1024 entries. On the 16384th clock edge after reset is released, and every 16384 edges after that, all entries are cleared in that single edge.
- R7: When a report and a periodic clear fall on the same edge, the reported entry is 1 afterwards and every other entry is 0.
- R8: A synchronous reset asserted mid-interval clears all entries and restarts the clear interval from zero.
- R9: With `violValid`=0, the value on `violPc` has no effect on any entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lookupPc | input | 32 | PC of the load asking for issue advice |
| lookupWait | output | 1 | 1: hold the load behind unresolved older stores; 0: may issue speculatively |
| violValid | input | 1 | An ordering violation is being reported this cycle |
| violPc | input | 32 | PC of the load that read stale data |

## Verification
The hardest case to reach from the ports is a violation report that lands on the exact edge where the periodic clear fires. The clear depends only on an internal counter that no port exposes. The bench keeps its own count of edges since reset and idles with random lookups until its count shows one edge left in the interval. It then drives a report on that edge and checks both the reported entry and an entry that was set earlier. A mid-interval reset follows, and a second clear is observed to confirm that the interval restarted.

// File: rtl/ldwait_pkg.sv
package ldwait_pkg;

  // Upper bound on the index slice width carried in the strobe struct
  localparam int unsigned IDX_MAX = 16;

  typedef struct packed {
    logic               clearAll; // wipe every wait flag this edge
    logic               setEn;    // set one wait flag this edge
    logic [IDX_MAX-1:0] setIdx;   // which flag to set (low bits used)
  } tbl_strobe_t;

endpackage

// File: rtl/ldwait_ctrl.sv
module ldwait_ctrl
  import ldwait_pkg::*;
#(
  parameter int unsigned PC_WIDTH       = 32,
  parameter int unsigned IDX_LSB        = 2,
  parameter int unsigned IDX_BITS       = 10,
  parameter int unsigned CLEAR_INTERVAL = 16384
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                violValid,
  input  logic [PC_WIDTH-1:0] violPc,
  output tbl_strobe_t         strobes
);

  localparam int unsigned CNT_W   = (CLEAR_INTERVAL > 1) ? $clog2(CLEAR_INTERVAL) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLEAR_INTERVAL - 1);

  logic [CNT_W-1:0] clrCnt;
  logic             wrapNow;

  assign wrapNow = (clrCnt == CNT_LAST);

  // Free-running interval counter; returns to zero on the clearing edge
  always_ff @(posedge clk) begin
    if (rst) begin
      clrCnt <= '0;
    end else if (wrapNow) begin
      clrCnt <= '0;
    end else begin
      clrCnt <= clrCnt + 1'b1;
    end
  end

  logic [IDX_BITS-1:0] violIdx;
  assign violIdx = violPc[IDX_LSB +: IDX_BITS];

  always_comb begin
    strobes          = '0;
    strobes.clearAll = wrapNow;
    strobes.setEn    = violValid;
    strobes.setIdx   = IDX_MAX'(violIdx);
  end

endmodule

// File: rtl/ldwait_table.sv
module ldwait_table
  import ldwait_pkg::*;
#(
  parameter int unsigned PC_WIDTH = 32,
  parameter int unsigned IDX_LSB  = 2,
  parameter int unsigned IDX_BITS = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  tbl_strobe_t         strobes,
  input  logic [PC_WIDTH-1:0] lookupPc,
  output logic                lookupWait
);

  localparam int unsigned ENTRIES = 1 << IDX_BITS;

  logic [ENTRIES-1:0]  waitBits;
  logic [IDX_BITS-1:0] rdIdx;
  logic [IDX_BITS-1:0] wrIdx;

  assign rdIdx = lookupPc[IDX_LSB +: IDX_BITS];
  assign wrIdx = strobes.setIdx[IDX_BITS-1:0];

  // One flop per entry; a set on the same edge as a global clear wins
  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    logic hitSet;
    assign hitSet = strobes.setEn && (wrIdx == IDX_BITS'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        waitBits[g] <= 1'b0;
      end else if (hitSet) begin
        waitBits[g] <= 1'b1;
      end else if (strobes.clearAll) begin
        waitBits[g] <= 1'b0;
      end
    end
  end

  // Combinational read of the current table state
  assign lookupWait = waitBits[rdIdx];

endmodule

// File: rtl/ldwait_predictor.sv
module ldwait_predictor
  import ldwait_pkg::*;
#(
  parameter int unsigned PC_WIDTH       = 32,
  parameter int unsigned IDX_LSB        = 2,
  parameter int unsigned IDX_BITS       = 10,
  parameter int unsigned CLEAR_INTERVAL = 16384
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [PC_WIDTH-1:0] lookupPc,
  output logic                lookupWait,
  input  logic                violValid,
  input  logic [PC_WIDTH-1:0] violPc
);

  tbl_strobe_t ctlStrobes;

  ldwait_ctrl #(
    .PC_WIDTH      (PC_WIDTH),
    .IDX_LSB       (IDX_LSB),
    .IDX_BITS      (IDX_BITS),
    .CLEAR_INTERVAL(CLEAR_INTERVAL)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .violValid(violValid),
    .violPc   (violPc),
    .strobes  (ctlStrobes)
  );

  ldwait_table #(
    .PC_WIDTH(PC_WIDTH),
    .IDX_LSB (IDX_LSB),
    .IDX_BITS(IDX_BITS)
  ) u_table (
    .clk       (clk),
    .rst       (rst),
    .strobes   (ctlStrobes),
    .lookupPc  (lookupPc),
    .lookupWait(lookupWait)
  );

endmodule

// File: rtl/ldwait_predictor_chk.sv
module ldwait_predictor_chk
  import ldwait_pkg::*;
#(
  parameter int unsigned PC_WIDTH       = 32,
  parameter int unsigned IDX_LSB        = 2,
  parameter int unsigned IDX_BITS       = 10,
  parameter int unsigned CLEAR_INTERVAL = 16384
) (
  input logic                clk,
  input logic                rst,
  input logic [PC_WIDTH-1:0] lookupPc,
  input logic                lookupWait,
  input logic                violValid,
  input logic [PC_WIDTH-1:0] violPc,
  input tbl_strobe_t         ctlStrobes
);

  // Independent edge counter since reset release
  int unsigned edgeCnt;
  always_ff @(posedge clk) begin
    if (rst) edgeCnt <= 0;
    else if (edgeCnt == CLEAR_INTERVAL - 1) edgeCnt <= 0;
    else edgeCnt <= edgeCnt + 1;
  end

  // R1
  reset_empty_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !lookupWait);

  // R2
  set_visible_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(violValid) &&
     lookupPc[IDX_LSB +: IDX_BITS] == $past(violPc[IDX_LSB +: IDX_BITS])) |-> lookupWait);

  // R6
  clear_period_chk: assert property (@(posedge clk) disable iff (rst)
    ctlStrobes.clearAll == (edgeCnt == CLEAR_INTERVAL - 1));

  // R6
  clear_empties_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ctlStrobes.clearAll) &&
     !($past(violValid) &&
       lookupPc[IDX_LSB +: IDX_BITS] == $past(violPc[IDX_LSB +: IDX_BITS]))) |-> !lookupWait);

  // R9
  no_report_no_set_chk: assert property (@(posedge clk) disable iff (rst)
    !violValid |-> !ctlStrobes.setEn);

endmodule

bind ldwait_predictor ldwait_predictor_chk #(
  .PC_WIDTH      (PC_WIDTH),
  .IDX_LSB       (IDX_LSB),
  .IDX_BITS      (IDX_BITS),
  .CLEAR_INTERVAL(CLEAR_INTERVAL)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .lookupPc  (lookupPc),
  .lookupWait(lookupWait),
  .violValid (violValid),
  .violPc    (violPc),
  .ctlStrobes(ctlStrobes)
);

// File: tb/ldwait_predictor_bench.sv
module ldwait_predictor_bench;

  localparam int unsigned PCW      = 32;
  localparam int unsigned LSB      = 2;
  localparam int unsigned IB       = 10;
  localparam int unsigned INTERVAL = 16384;
  localparam int unsigned ENT      = 1 << IB;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [PCW-1:0] lookupPc = '0;
  logic           lookupWait;
  logic           violValid = 1'b0;
  logic [PCW-1:0] violPc = '0;

  always #10 clk = ~clk; // 50 MHz

  ldwait_predictor u_ldwait_predictor (
    .clk       (clk),
    .rst       (rst),
    .lookupPc  (lookupPc),
    .lookupWait(lookupWait),
    .violValid (violValid),
    .violPc    (violPc)
  );

  bit          model [ENT];
  int unsigned modelCnt = 0;
  int          total = 0;
  int          bad = 0;

  function automatic int unsigned idxOf(input logic [PCW-1:0] pc);
    return int'(pc[LSB +: IB]);
  endfunction

  function automatic bit expectWait(input logic [PCW-1:0] pc);
    return model[idxOf(pc)];
  endfunction

  function automatic logic [PCW-1:0] poolPc();
    // small pool so reports and lookups collide often
    return {$urandom_range(3, 0), 18'h0, 10'($urandom_range(31, 0)) , 2'($urandom_range(3, 0))} ;
  endfunction

  task automatic check(input logic [PCW-1:0] pc, input string tag);
    bit exp;
    exp = expectWait(pc);
    total++;
    if (lookupWait !== exp) begin
      bad++;
      $display("FAIL %s pc=%h lookupWait=%b expected=%b", tag, pc, lookupWait, exp);
    end
  endtask

  // One clock cycle: drive at negedge, check, then advance the model at posedge
  task automatic cycle(input bit r, input bit v, input logic [PCW-1:0] vpc,
                       input logic [PCW-1:0] lpc, input bit doCheck, input string tag);
    @(negedge clk);
    rst       = r;
    violValid = v;
    violPc    = vpc;
    lookupPc  = lpc;
    #1;
    if (doCheck) check(lpc, tag);
    @(posedge clk);
    if (r) begin
      foreach (model[i]) model[i] = 1'b0;
      modelCnt = 0;
    end else begin
      if (modelCnt == INTERVAL - 1) begin
        foreach (model[i]) model[i] = 1'b0;
        modelCnt = 0;
      end else begin
        modelCnt++;
      end
      if (v) model[idxOf(vpc)] = 1'b1;
    end
  endtask

  task automatic idleUntilLastEdge(input string tag);
    while (modelCnt != INTERVAL - 1) cycle(1'b0, 1'b0, '0, poolPc(), 1'b1, tag);
  endtask

  localparam logic [PCW-1:0] PC_A = 32'h0000_1234;
  localparam logic [PCW-1:0] PC_B = 32'h0000_2ab8;
  localparam logic [PCW-1:0] PC_C = 32'h0000_0f00;

  initial begin
    void'($urandom(32'd20240611));
    foreach (model[i]) model[i] = 1'b0;
    cycle(1'b1, 1'b0, '0, '0, 1'b0, "");
    cycle(1'b1, 1'b0, '0, '0, 1'b0, "");

    // R1: empty after reset
    for (int k = 0; k < 16; k++) cycle(1'b0, 1'b0, '0, poolPc(), 1'b1, "R1");

    // R3: same-cycle lookup sees the old flag
    cycle(1'b0, 1'b1, PC_A, PC_A, 1'b1, "R3");
    // R2: visible next cycle
    cycle(1'b0, 1'b0, '0, PC_A, 1'b1, "R2");
    // R4: aliases through low and high PC bits
    cycle(1'b0, 1'b0, '0, PC_A ^ 32'hf000_0003, 1'b1, "R4");
    cycle(1'b0, 1'b0, '0, PC_A | 32'h0010_0000, 1'b1, "R4");
    // R5: neighbouring entry untouched
    cycle(1'b0, 1'b0, '0, PC_A + 32'd4, 1'b1, "R5");
    cycle(1'b0, 1'b0, '0, PC_B, 1'b1, "R5");
    // R9: report PC without valid
    cycle(1'b0, 1'b0, PC_B, PC_B, 1'b1, "R9");
    cycle(1'b0, 1'b0, '0, PC_B, 1'b1, "R9");

    // R2: random mix of reports and lookups
    for (int k = 0; k < 3000; k++)
      cycle(1'b0, ($urandom_range(7, 0) == 0), poolPc(), poolPc(), 1'b1, "R2");

    // R6 / R7: reach the clearing edge and report on it
    cycle(1'b0, 1'b1, PC_B, PC_A, 1'b1, "R5");
    idleUntilLastEdge("R6");
    cycle(1'b0, 1'b1, PC_C, PC_A, 1'b1, "R6");
    cycle(1'b0, 1'b0, '0, PC_C, 1'b1, "R7");
    cycle(1'b0, 1'b0, '0, PC_A, 1'b1, "R7");
    cycle(1'b0, 1'b0, '0, PC_B, 1'b1, "R6");

    // R8: mid-interval reset
    for (int k = 0; k < 500; k++)
      cycle(1'b0, ($urandom_range(3, 0) == 0), poolPc(), poolPc(), 1'b1, "R2");
    cycle(1'b1, 1'b0, '0, '0, 1'b0, "");
    for (int k = 0; k < 8; k++) cycle(1'b0, 1'b0, '0, poolPc(), 1'b1, "R8");
    cycle(1'b0, 1'b1, PC_B, PC_B, 1'b1, "R8");
    for (int k = 0; k < 16000; k++) cycle(1'b0, 1'b0, '0, PC_B, 1'b1, "R8");
    idleUntilLastEdge("R6");
    cycle(1'b0, 1'b0, '0, PC_B, 1'b1, "R6");
    cycle(1'b0, 1'b0, '0, PC_B, 1'b1, "R6");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule